// File: doc/BRIEF.md
# Floating-Point Exponent Compare Unit

This execution unit takes two 64-bit double-precision words and compares only their biased exponent fields. It produces a four-flag condition result: less, greater, equal and unordered. A NaN in either operand forces the unordered flag and clears the other three. The sign bit takes no part, and the fraction is used only for its zero test, which separates a NaN from an infinity. Values of lower precision held in double format therefore compare correctly as well.

A valid request supplies the two operand words, a 3-bit destination field selector and the vector-facility enable bit. One cycle later the unit writes the four flags into the selected 4-bit field of a 32-bit, eight-field condition register. It also copies the same four bits into a floating-point condition code and raises a valid strobe. If the facility is disabled, the unit raises a one-cycle unavailable-exception strobe and leaves both the condition register and the condition code untouched. The unit also forms the two 6-bit source register indices from an extension bit and a 5-bit field per source.

Top module: `fpexp_cmp_unit`

## Requirements
- R1: The exponent fields (bits [62:52], LSB-first numbering) are compared as unsigned 11-bit numbers. With bit 3 = less, bit 2 = greater, bit 1 = equal and bit 0 = unordered, the result is 4'b1000 when A's exponent is smaller, 4'b0100 when it is larger, and 4'b0010 when the two are equal.
- R2: The sign bit [63] and the magnitude of the fraction [51:0] do not affect the result of ordered operands.
- R3: An operand whose exponent is 2047 and whose fraction is nonzero is a NaN. If either operand is a NaN, the result is exactly 4'b0001.
- R4: An infinity (exponent 2047, zero fraction) is not a NaN and compares by its exponent like any other value.
- R5: The result is written into the condition register field chosen by the selector. Field 0 is cr[31:28] and field k is cr[31-4k -: 4]. All other fields keep their values.
- R6: The floating-point condition code receives the same four bits as the written field.
- R7: When in_valid and the enable bit are both 1, the condition register, the condition code and out_valid update on the next clock edge, giving a latency of one cycle.
- R8: When in_valid is 1 and the enable bit is 0, unavail_exc is 1 for the next cycle only, out_valid stays 0, and neither the condition register nor the condition code changes.
- R9: Each source index equals 32 × extension bit + 5-bit field, given as a 6-bit value with the extension bit as its MSB. This is combinational.
- R10: Synchronous active-high reset clears the condition register, the condition code, out_valid and unavail_exc.
- R11: A cycle with in_valid at 0 changes no state and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| vec_en | input | 1 | Vector facility enable |
| op_a | input | 64 | First operand word |
| op_b | input | 64 | Second operand word |
| dst_field | input | 3 | Destination condition field selector |
| src_a_ext | input | 1 | Extension bit for source A index |
| src_a_fld | input | 5 | Field for source A index |
| src_b_ext | input | 1 | Extension bit for source B index |
| src_b_fld | input | 5 | Field for source B index |
| src_a_idx | output | 6 | Composed source A register index |
| src_b_idx | output | 6 | Composed source B register index |
| cr_q | output | 32 | Condition register |
| fpcc_q | output | 4 | Floating-point condition code |
| out_valid | output | 1 | Result written strobe |
| unavail_exc | output | 1 | Facility-unavailable exception strobe |

## Verification
Random operand pairs are drawn with exponents from a small pool, so that equal exponents occur often alongside both orderings. Random signs and fractions then show that neither changes an ordered result. Directed pairs place infinities against finite values, against each other and against NaNs, which separates the all-ones exponent case from true NaN detection. Random field selectors run over a bench-kept model of the whole register, so a write that spills into a neighbouring nibble is caught. Interleaved disabled and idle requests show that those cycles leave the register and condition code untouched.

// File: rtl/fpexp_pkg.sv
package fpexp_pkg;
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic uo;
  } cond_t;
endpackage

// File: rtl/fpexp_classify.sv
module fpexp_classify #(
  parameter int DW = 64,
  parameter int EW = 11,
  parameter int FW = 52
) (
  input  logic [DW-1:0] word,
  output logic [EW-1:0] expo,
  output logic          is_nan
);
  always_comb begin
    expo   = word[FW +: EW];
    is_nan = (&word[FW +: EW]) && (|word[FW-1:0]);
  end
endmodule

// File: rtl/fpexp_compare.sv
module fpexp_compare
  import fpexp_pkg::*;
#(
  parameter int EW = 11
) (
  input  logic [EW-1:0] exp_a,
  input  logic [EW-1:0] exp_b,
  input  logic          nan_a,
  input  logic          nan_b,
  output cond_t         cond
);
  logic unord;
  always_comb begin
    unord   = nan_a | nan_b;
    cond.uo = unord;
    cond.lt = !unord && (exp_a < exp_b);
    cond.gt = !unord && (exp_a > exp_b);
    cond.eq = !unord && (exp_a == exp_b);
  end
endmodule

// File: rtl/fpexp_crmerge.sv
module fpexp_crmerge #(
  parameter int NFIELD  = 8,
  parameter int FIELD_W = 4,
  localparam int SELW   = $clog2(NFIELD),
  localparam int CRW    = NFIELD * FIELD_W
) (
  input  logic [CRW-1:0]     cr_in,
  input  logic [SELW-1:0]    sel,
  input  logic [FIELD_W-1:0] nib,
  output logic [CRW-1:0]     cr_out
);
  for (genvar k = 0; k < NFIELD; k++) begin : g_field
    localparam int HI = CRW - 1 - k * FIELD_W;
    always_comb begin
      if (sel == SELW'(k)) cr_out[HI -: FIELD_W] = nib;
      else                 cr_out[HI -: FIELD_W] = cr_in[HI -: FIELD_W];
    end
  end
endmodule

// File: rtl/fpexp_cmp_unit.sv
module fpexp_cmp_unit
  import fpexp_pkg::*;
#(
  parameter int DW      = 64,
  parameter int EW      = 11,
  parameter int FW      = 52,
  parameter int NFIELD  = 8,
  parameter int FIELD_W = 4,
  parameter int IDXW    = 5,
  localparam int SELW   = $clog2(NFIELD),
  localparam int CRW    = NFIELD * FIELD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              vec_en,
  input  logic [DW-1:0]     op_a,
  input  logic [DW-1:0]     op_b,
  input  logic [SELW-1:0]   dst_field,
  input  logic              src_a_ext,
  input  logic [IDXW-1:0]   src_a_fld,
  input  logic              src_b_ext,
  input  logic [IDXW-1:0]   src_b_fld,
  output logic [IDXW:0]     src_a_idx,
  output logic [IDXW:0]     src_b_idx,
  output logic [CRW-1:0]    cr_q,
  output logic [FIELD_W-1:0] fpcc_q,
  output logic              out_valid,
  output logic              unavail_exc
);
  logic [DW-1:0] ops   [2];
  logic [EW-1:0] expos [2];
  logic          nans  [2];
  cond_t         cond;
  logic [CRW-1:0] cr_next;

  assign ops[0]    = op_a;
  assign ops[1]    = op_b;
  assign src_a_idx = {src_a_ext, src_a_fld};
  assign src_b_idx = {src_b_ext, src_b_fld};

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fpexp_classify #(.DW(DW), .EW(EW), .FW(FW)) u_cls (
      .word(ops[i]), .expo(expos[i]), .is_nan(nans[i])
    );
  end

  fpexp_compare #(.EW(EW)) u_cmp (
    .exp_a(expos[0]), .exp_b(expos[1]),
    .nan_a(nans[0]), .nan_b(nans[1]), .cond(cond)
  );

  fpexp_crmerge #(.NFIELD(NFIELD), .FIELD_W(FIELD_W)) u_merge (
    .cr_in(cr_q), .sel(dst_field), .nib(cond), .cr_out(cr_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cr_q        <= '0;
      fpcc_q      <= '0;
      out_valid   <= 1'b0;
      unavail_exc <= 1'b0;
    end else begin
      out_valid   <= in_valid && vec_en;
      unavail_exc <= in_valid && !vec_en;
      if (in_valid && vec_en) begin
        cr_q   <= cr_next;
        fpcc_q <= cond;
      end
    end
  end
endmodule

// File: rtl/fpexp_cmp_unit_chk.sv
module fpexp_cmp_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        vec_en,
  input logic [63:0] op_a,
  input logic [63:0] op_b,
  input logic [2:0]  dst_field,
  input logic [31:0] cr_q,
  input logic [3:0]  fpcc_q,
  input logic        out_valid,
  input logic        unavail_exc
);
  function automatic logic [3:0] nib_of(input logic [31:0] c, input logic [2:0] s);
    return c[31 - 4*s -: 4];
  endfunction

  logic any_nan;
  assign any_nan = ((&op_a[62:52]) && (|op_a[51:0])) || ((&op_b[62:52]) && (|op_b[51:0]));

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid && vec_en |=> out_valid && !unavail_exc); // R7
  AST_UNAVAIL_HOLD: assert property (@(posedge clk) disable iff (rst)
    in_valid && !vec_en |=> unavail_exc && !out_valid && $stable(cr_q) && $stable(fpcc_q)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !unavail_exc && $stable(cr_q) && $stable(fpcc_q)); // R11
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones(fpcc_q) == 1); // R1
  AST_NAN_UNORD: assert property (@(posedge clk) disable iff (rst)
    in_valid && vec_en && any_nan |=> fpcc_q == 4'b0001); // R3
  AST_FIELD_MIRROR: assert property (@(posedge clk) disable iff (rst)
    in_valid && vec_en |=> nib_of(cr_q, $past(dst_field)) == fpcc_q); // R6
endmodule

bind fpexp_cmp_unit fpexp_cmp_unit_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .vec_en(vec_en),
  .op_a(op_a), .op_b(op_b), .dst_field(dst_field),
  .cr_q(cr_q), .fpcc_q(fpcc_q), .out_valid(out_valid), .unavail_exc(unavail_exc)
);

// File: tb/tb_fpexp_cmp_unit.sv
module tb_fpexp_cmp_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic in_valid = 0, vec_en = 0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [2:0] dst_field = '0;
  logic src_a_ext = 0, src_b_ext = 0;
  logic [4:0] src_a_fld = '0, src_b_fld = '0;
  logic [5:0] src_a_idx, src_b_idx;
  logic [31:0] cr_q;
  logic [3:0] fpcc_q;
  logic out_valid, unavail_exc;

  int checks = 0, fails = 0;
  logic [31:0] m_cr = '0;
  logic [3:0]  m_cc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpexp_cmp_unit dut (.*);

  function automatic logic [3:0] ref_cond(input logic [63:0] a, input logic [63:0] b);
    logic [10:0] ea = a[62:52], eb = b[62:52];
    logic na = (ea == 11'd2047) && (a[51:0] != 0);
    logic nb = (eb == 11'd2047) && (b[51:0] != 0);
    if (na || nb) return 4'b0001;
    if (ea < eb) return 4'b1000;
    if (ea > eb) return 4'b0100;
    return 4'b0010;
  endfunction

  function automatic logic [63:0] mk(input logic s, input logic [10:0] e, input logic [51:0] f);
    return {s, e, f};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic op(input logic [63:0] a, input logic [63:0] b, input logic [2:0] f,
                    input logic en, input string req);
    logic [3:0] c;
    @(negedge clk);
    op_a = a; op_b = b; dst_field = f; vec_en = en; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    if (en) begin
      c = ref_cond(a, b);
      m_cr[31 - 4*f -: 4] = c;
      m_cc = c;
    end
    chk({req, " fpcc"}, 64'(fpcc_q), 64'(m_cc));
    chk({req, " cr"}, 64'(cr_q), 64'(m_cr));
    chk("R7 out_valid", 64'(out_valid), 64'(en));
    chk("R8 unavail_exc", 64'(unavail_exc), 64'(!en));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R10 cr reset", 64'(cr_q), 0);
    chk("R10 fpcc reset", 64'(fpcc_q), 0);
    chk("R10 strobes reset", 64'({out_valid, unavail_exc}), 0);

    // R9 index composition
    for (int i = 0; i < 8; i++) begin
      src_a_ext = i[0]; src_a_fld = 5'($urandom);
      src_b_ext = i[1]; src_b_fld = 5'($urandom);
      #1;
      chk("R9 idx a", 64'(src_a_idx), 64'(32*src_a_ext + src_a_fld));
      chk("R9 idx b", 64'(src_b_idx), 64'(32*src_b_ext + src_b_fld));
    end

    // R1 orderings, R5 field placement
    op(mk(0, 11'd100, 0), mk(0, 11'd200, 0), 3'd0, 1, "R1 less R5 f0");
    op(mk(0, 11'd300, 0), mk(0, 11'd200, 0), 3'd7, 1, "R1 greater R5 f7");
    op(mk(0, 11'd5, 1), mk(0, 11'd5, 52'hFFFFF), 3'd3, 1, "R1 equal");
    // R2 sign and fraction ignored
    op(mk(1, 11'd10, '1), mk(0, 11'd11, 0), 3'd1, 1, "R2 sign/frac less");
    op(mk(0, 11'd12, 0), mk(1, 11'd12, '1), 3'd2, 1, "R2 sign/frac equal");
    // R4 infinities
    op(mk(0, 11'd2047, 0), mk(1, 11'd2047, 0), 3'd4, 1, "R4 inf eq inf");
    op(mk(0, 11'd2047, 0), mk(0, 11'd2046, '1), 3'd5, 1, "R4 inf gt max");
    op(mk(1, 11'd0, 0), mk(0, 11'd2047, 0), 3'd6, 1, "R4 zero lt inf");
    // R3 NaNs
    op(mk(0, 11'd2047, 1), mk(0, 11'd2047, 0), 3'd6, 1, "R3 nan vs inf");
    op(mk(0, 11'd3, 0), mk(1, 11'd2047, 52'h8000000000000), 3'd2, 1, "R3 nan in b");
    op(mk(0, 11'd2047, '1), mk(0, 11'd2047, '1), 3'd0, 1, "R3 both nan");
    // R8 disabled request
    op(mk(0, 11'd1, 0), mk(0, 11'd9, 0), 3'd5, 0, "R8 disabled no write");
    // R11 idle cycles
    repeat (3) @(negedge clk);
    chk("R11 idle cr", 64'(cr_q), 64'(m_cr));
    chk("R11 idle strobes", 64'({out_valid, unavail_exc}), 0);

    // random mix, R5/R6 over a model of the whole register
    for (int n = 0; n < 400; n++) begin
      logic [10:0] pool [6] = '{11'd0, 11'd1, 11'd1023, 11'd1024, 11'd2046, 11'd2047};
      logic [10:0] ea, eb;
      logic [51:0] fa, fb;
      ea = ($urandom % 2) ? pool[$urandom % 6] : 11'($urandom);
      eb = ($urandom % 3 == 0) ? ea : (($urandom % 2) ? pool[$urandom % 6] : 11'($urandom));
      fa = ($urandom % 3 == 0) ? 52'd0 : {20'($urandom), 32'($urandom)};
      fb = ($urandom % 3 == 0) ? 52'd0 : {20'($urandom), 32'($urandom)};
      op(mk(1'($urandom), ea, fa), mk(1'($urandom), eb, fb), 3'($urandom),
         ($urandom % 8) != 0, "R5 R6 random");
      if ($urandom % 4 == 0) @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule